// File: doc/BRIEF.md
# Dual-Channel Converter Input Router

This block sits in front of a two-channel (I and Q) digital-to-analog converter core. On each rising clock edge it registers the incoming 14-bit data, an inversion control and a channel-steering bit. It then delivers one offset-binary code per channel, and each channel has its own update strobe. A static port-mode level picks one of two routing schemes. In parallel operation two buses run side by side, one per channel. In interleaved operation a single bus carries words for both channels, and each word carries its own steering bit.

Before a word enters its channel pipeline, the block can invert every data bit. When the format level marks the data as two's complement, it also re-biases the word to offset binary. Each channel then runs through a fixed-length pipeline whose length depends on the port mode. Parallel operation ends in a falling-edge register, which gives a half-cycle latency. A power-down level forces both outputs to the midscale code. The outputs stay there until a parameterised wake-up count has elapsed after power-down is released, and also after reset.

Top module: `dac_front_router`

## Requirements
- R1: With `port_mode` = 1 (parallel), each captured `bus_a` word drives the Q channel and each captured `bus_b` word drives the I channel, on every clock.
- R2: With `port_mode` = 0 (interleaved), only `bus_b` is used. A word captured with `steer_i` = 1 goes to I, and a word captured with `steer_i` = 0 goes to Q.
- R3: A word captured with `inv_en` = 1 has all 14 bits inverted before format decoding. With `inv_en` = 0 the bits pass unchanged.
- R4: With `twos_fmt` = 1, the word after inversion is re-biased by adding 0x2000 modulo 2^14. So 0x2000 gives code 0x0000, 0x1FFF gives 0x3FFF, and 0x0000 gives 0x2000. With `twos_fmt` = 0 the word is output as is.
- R5: In parallel mode, a word captured at rising edge E appears on both code outputs at the falling edge that follows edge E+5 (5.5 cycles later). Each strobe is high from that falling edge until the next falling edge.
- R6: In interleaved mode, an I word captured at edge E appears on `i_code` at rising edge E+9 and a Q word at rising edge E+8. The matching strobe is high for exactly the following cycle.
- R7: In interleaved mode, a channel output holds its last code, with its strobe low, in every cycle in which no word for that channel arrives. `bus_a` has no effect.
- R8: While `pwr_dn` = 1, and for at least WAKE_CYCLES clocks after it returns to 0, both codes read midscale 0x2000 and both strobes are low.
- R9: After reset, both codes read 0x2000 and both strobes are low. The block then runs its wake-up count before passing data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; input capture on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_mode | input | 1 | 1 = two-bus parallel, 0 = single-bus interleaved |
| twos_fmt | input | 1 | 1 = input words are two's complement, 0 = offset binary |
| pwr_dn | input | 1 | 1 = power down; outputs parked at midscale |
| inv_en | input | 1 | Per-word inversion control, captured with the data |
| steer_i | input | 1 | Interleaved-mode channel select, captured with the data (1 = I) |
| bus_a | input | 14 | Q-channel data in parallel mode; unused when interleaved |
| bus_b | input | 14 | I-channel data in parallel mode; shared bus when interleaved |
| i_code | output | 14 | I-channel offset-binary code |
| i_stb | output | 1 | I-channel new-code strobe |
| q_code | output | 14 | Q-channel offset-binary code |
| q_stb | output | 1 | Q-channel new-code strobe |

## Verification
Some rules can be checked on every cycle. The assertions check that power-down parks both channels at midscale with strobes low, and that the awake state drops right after power-down is raised. They also check that an interleaved channel's code never moves without its strobe. Routing, inversion, format decoding and the exact latencies (5.5, 9 and 8 cycles) depend on which word entered and when. Only the bench's scenarios can show these: they track every captured word and compute the expected code arithmetically at the cycle it must emerge.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
   typedef enum logic {
      MODE_INTERLEAVED = 1'b0,
      MODE_PARALLEL    = 1'b1
   } port_mode_e;

   function automatic int unsigned tap_of(int unsigned latency);
      return (latency > 0) ? latency - 1 : 0;
   endfunction
endpackage

// File: rtl/dfr_wake.sv
module dfr_wake #(
   parameter int unsigned WAKE_CYCLES = 2000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_dn,
   output logic awake
);
   localparam int unsigned CW = $clog2(WAKE_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         awake <= 1'b0;
      end else if (pwr_dn) begin
         cnt   <= '0;
         awake <= 1'b0;
      end else if (!awake) begin
         if (cnt == LAST) awake <= 1'b1;
         else             cnt   <= cnt + 1'b1;
      end
   end

   a_r8_sleep_on_request: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> !awake);
   a_r8_wake_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(awake) |-> $past(!pwr_dn));
endmodule

// File: rtl/dfr_capture.sv
module dfr_capture #(
   parameter int unsigned DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              awake,
   input  logic              port_mode,
   input  logic              twos_fmt,
   input  logic              inv_en,
   input  logic              steer_i,
   input  logic [DATA_W-1:0] bus_a,
   input  logic [DATA_W-1:0] bus_b,
   output logic              i_vld,
   output logic [DATA_W-1:0] i_word,
   output logic              q_vld,
   output logic [DATA_W-1:0] q_word
);
   import dfr_pkg::*;

   logic [DATA_W-1:0] a_q, b_q;
   logic              inv_q, steer_q, live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q     <= '0;
         b_q     <= '0;
         inv_q   <= 1'b0;
         steer_q <= 1'b0;
         live_q  <= 1'b0;
      end else begin
         a_q     <= bus_a;
         b_q     <= bus_b;
         inv_q   <= inv_en;
         steer_q <= steer_i;
         live_q  <= awake;
      end
   end

   function automatic logic [DATA_W-1:0] decode(input logic [DATA_W-1:0] raw,
                                                input logic inv, input logic twos);
      logic [DATA_W-1:0] x;
      x = raw ^ {DATA_W{inv}};
      if (twos) x[DATA_W-1] = ~x[DATA_W-1];
      return x;
   endfunction

   logic par;
   assign par    = (port_mode == MODE_PARALLEL);
   assign i_vld  = live_q & (par | steer_q);
   assign q_vld  = live_q & (par | ~steer_q);
   assign i_word = decode(b_q, inv_q, twos_fmt);
   assign q_word = decode(par ? a_q : b_q, inv_q, twos_fmt);
endmodule

// File: rtl/dfr_lane.sv
module dfr_lane #(
   parameter int unsigned DATA_W   = 14,
   parameter int unsigned IL_TAP   = 8,
   parameter int unsigned PAR_TAP  = 5,
   parameter bit          PAR_HALF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              awake,
   input  logic              port_mode,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_word,
   output logic [DATA_W-1:0] code,
   output logic              stb
);
   import dfr_pkg::*;

   localparam int unsigned DEPTH = (IL_TAP > PAR_TAP) ? IL_TAP : PAR_TAP;
   localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

   if (IL_TAP < 1 || PAR_TAP < 1) begin : g_bad_tap
      $error("dfr_lane: taps must be at least one stage");
   end

   logic [DEPTH:1]             stg_vld;
   logic [DEPTH:1][DATA_W-1:0] stg_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_vld  <= '0;
         stg_word <= '0;
      end else begin
         stg_vld[1]  <= in_vld & awake;
         stg_word[1] <= in_word;
         for (int s = 2; s <= DEPTH; s++) begin
            stg_vld[s]  <= stg_vld[s-1] & awake;
            stg_word[s] <= stg_word[s-1];
         end
      end
   end

   // interleaved output: rising edge, updates only when its word arrives
   logic [DATA_W-1:0] il_code;
   logic              il_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         il_code <= MID;
         il_stb  <= 1'b0;
      end else if (!awake) begin
         il_code <= MID;
         il_stb  <= 1'b0;
      end else begin
         il_stb <= stg_vld[IL_TAP];
         if (stg_vld[IL_TAP]) il_code <= stg_word[IL_TAP];
      end
   end

   // parallel output: optional half-cycle register
   logic [DATA_W-1:0] par_code;
   logic              par_stb;

   if (PAR_HALF) begin : g_par_fall
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) begin
            par_code <= MID;
            par_stb  <= 1'b0;
         end else if (!awake) begin
            par_code <= MID;
            par_stb  <= 1'b0;
         end else begin
            par_stb <= stg_vld[PAR_TAP];
            if (stg_vld[PAR_TAP]) par_code <= stg_word[PAR_TAP];
         end
      end
   end else begin : g_par_rise
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            par_code <= MID;
            par_stb  <= 1'b0;
         end else if (!awake) begin
            par_code <= MID;
            par_stb  <= 1'b0;
         end else begin
            par_stb <= stg_vld[PAR_TAP];
            if (stg_vld[PAR_TAP]) par_code <= stg_word[PAR_TAP];
         end
      end
   end

   assign code = (port_mode == MODE_PARALLEL) ? par_code : il_code;
   assign stb  = (port_mode == MODE_PARALLEL) ? par_stb  : il_stb;

   a_r8_parked_midscale: assert property (@(posedge clk) disable iff (!rst_n)
      (!awake && $past(!awake)) |-> (code == MID && !stb));
   a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (port_mode == MODE_INTERLEAVED && $past(port_mode) == MODE_INTERLEAVED &&
       awake && $past(awake) && !stb) |-> $stable(code));
endmodule

// File: rtl/dac_front_router.sv
module dac_front_router #(
   parameter int unsigned DATA_W      = 14,
   parameter int unsigned LAT_PAR     = 5,
   parameter bit          PAR_HALF    = 1'b1,
   parameter int unsigned LAT_IL_I    = 9,
   parameter int unsigned LAT_IL_Q    = 8,
   parameter int unsigned WAKE_CYCLES = 2000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_mode,
   input  logic              twos_fmt,
   input  logic              pwr_dn,
   input  logic              inv_en,
   input  logic              steer_i,
   input  logic [DATA_W-1:0] bus_a,
   input  logic [DATA_W-1:0] bus_b,
   output logic [DATA_W-1:0] i_code,
   output logic              i_stb,
   output logic [DATA_W-1:0] q_code,
   output logic              q_stb
);
   import dfr_pkg::*;

   localparam int unsigned TAP_I = tap_of(LAT_IL_I);
   localparam int unsigned TAP_Q = tap_of(LAT_IL_Q);
   localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

   if (DATA_W < 2) begin : g_bad_width
      $error("dac_front_router: DATA_W must be at least 2");
   end
   if (LAT_IL_I < 2 || LAT_IL_Q < 2 || LAT_PAR < 1) begin : g_bad_lat
      $error("dac_front_router: latencies too short for the pipeline");
   end
   if (WAKE_CYCLES < 1) begin : g_bad_wake
      $error("dac_front_router: WAKE_CYCLES must be at least 1");
   end

   logic awake;
   logic              cap_i_vld, cap_q_vld;
   logic [DATA_W-1:0] cap_i_word, cap_q_word;

   dfr_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .awake(awake)
   );

   dfr_capture #(.DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .awake(awake), .port_mode(port_mode),
      .twos_fmt(twos_fmt), .inv_en(inv_en), .steer_i(steer_i),
      .bus_a(bus_a), .bus_b(bus_b),
      .i_vld(cap_i_vld), .i_word(cap_i_word),
      .q_vld(cap_q_vld), .q_word(cap_q_word)
   );

   dfr_lane #(.DATA_W(DATA_W), .IL_TAP(TAP_I), .PAR_TAP(LAT_PAR), .PAR_HALF(PAR_HALF)) u_lane_i (
      .clk(clk), .rst_n(rst_n), .awake(awake), .port_mode(port_mode),
      .in_vld(cap_i_vld), .in_word(cap_i_word), .code(i_code), .stb(i_stb)
   );

   dfr_lane #(.DATA_W(DATA_W), .IL_TAP(TAP_Q), .PAR_TAP(LAT_PAR), .PAR_HALF(PAR_HALF)) u_lane_q (
      .clk(clk), .rst_n(rst_n), .awake(awake), .port_mode(port_mode),
      .in_vld(cap_q_vld), .in_word(cap_q_word), .code(q_code), .stb(q_stb)
   );

   a_r8_pd_forces_midscale: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pwr_dn) && $past(pwr_dn, 2)) |->
         (i_code == MID && q_code == MID && !i_stb && !q_stb));
endmodule

// File: tb/dac_front_router_test.sv
module dac_front_router_test;
   localparam int W  = 14;
   localparam int WK = 20;
   localparam int HN = 4096;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0, port_mode = 1'b1, twos_fmt = 1'b0, pwr_dn = 1'b0;
   logic inv_en = 1'b0, steer_i = 1'b0;
   logic [W-1:0] bus_a = '0, bus_b = '0;
   logic [W-1:0] i_code, q_code;
   logic i_stb, q_stb;

   dac_front_router #(.WAKE_CYCLES(WK)) uut (
      .clk(clk), .rst_n(rst_n), .port_mode(port_mode), .twos_fmt(twos_fmt),
      .pwr_dn(pwr_dn), .inv_en(inv_en), .steer_i(steer_i),
      .bus_a(bus_a), .bus_b(bus_b),
      .i_code(i_code), .i_stb(i_stb), .q_code(q_code), .q_stb(q_stb)
   );

   int checks = 0, errors = 0;
   int m = 0;        // index of the last rising edge seen
   int ps = 0;       // first capture edge of the current phase
   int inph = 0;     // cycles into current phase
   int chk_kind = 0; // 0 none, 1 parallel, 2 interleaved, 3 midscale
   int inv_style = 0, sel_style = 0;
   string tag = "";
   logic [W-1:0] hA [HN];
   logic [W-1:0] hB [HN];
   bit hInv [HN];
   bit hSel [HN];
   logic [W-1:0] lastI, lastQ;
   bit haveI, haveQ, expIs, expQs;

   task automatic chk(input string t, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (edge %0d)", t, act, exp, m + 1);
      end
   endtask

   function automatic logic [W-1:0] expect_code(input logic [W-1:0] v, input bit inv, input bit twos);
      int x;
      x = inv ? (16383 - int'(v)) : int'(v);
      if (twos) x = (x + 8192) % 16384;
      return W'(x);
   endfunction

   function automatic logic [W-1:0] pat(input int n, input int salt);
      case (n % 8)
         0: return 14'h2000;
         1: return 14'h1FFF;
         2: return 14'h0000;
         3: return 14'h3FFF;
         default: return W'((n * 2749 + salt * 613 + 77) % 16384);
      endcase
   endfunction

   task automatic cyc();
      int nx, e;
      @(posedge clk);
      m++;
      #1;
      nx = m + 1;
      bus_a   = pat(nx, 3);
      bus_b   = pat(nx + (nx / 8), 11);
      inv_en  = (inv_style == 0) ? 1'b0 : 1'(((nx * 5) / 3) % 2);
      steer_i = (sel_style == 0) ? 1'b0 : 1'(((nx * 7) / 4) % 2);
      hA[nx % HN] = bus_a;  hB[nx % HN] = bus_b;
      hInv[nx % HN] = inv_en; hSel[nx % HN] = steer_i;
      inph++;
      #7;
      // sample just before edge nx
      if (chk_kind == 1 && inph > 10) begin
         e = nx - 6;
         chk({tag, " I code"}, i_code, expect_code(hB[e % HN], hInv[e % HN], twos_fmt));
         chk({tag, " Q code"}, q_code, expect_code(hA[e % HN], hInv[e % HN], twos_fmt));
         chk({tag, " strobes"}, W'({i_stb, q_stb}), W'(2'b11));
      end else if (chk_kind == 2) begin
         e = nx - 10;
         expIs = 1'b0; expQs = 1'b0;
         if (e >= ps && hSel[e % HN]) begin
            lastI = expect_code(hB[e % HN], hInv[e % HN], twos_fmt);
            haveI = 1'b1; expIs = 1'b1;
         end
         e = nx - 9;
         if (e >= ps && !hSel[e % HN]) begin
            lastQ = expect_code(hB[e % HN], hInv[e % HN], twos_fmt);
            haveQ = 1'b1; expQs = 1'b1;
         end
         if (inph > 12 && haveI && haveQ) begin
            chk({tag, " I code"}, i_code, lastI);
            chk({tag, " Q code"}, q_code, lastQ);
            chk({tag, " I strobe"}, W'(i_stb), W'(expIs));
            chk({tag, " Q strobe"}, W'(q_stb), W'(expQs));
         end
      end else if (chk_kind == 3) begin
         chk({tag, " I midscale"}, i_code, 14'h2000);
         chk({tag, " Q midscale"}, q_code, 14'h2000);
         chk({tag, " strobes low"}, W'({i_stb, q_stb}), W'(0));
      end
   endtask

   task automatic phase(input bit mode, input bit fmt, input int invs, input int sels,
                        input int n, input string t);
      port_mode = mode; twos_fmt = fmt; inv_style = invs; sel_style = sels;
      tag = t; ps = m + 2; inph = 0; haveI = 1'b0; haveQ = 1'b0;
      chk_kind = mode ? 1 : 2;
      for (int k = 0; k < n; k++) cyc();
   endtask

   bit finished = 1'b0;

   initial begin
      #100000;
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R9: reset state
      chk("R9 I reset", i_code, 14'h2000);
      chk("R9 Q reset", q_code, 14'h2000);
      chk("R9 strobes reset", W'({i_stb, q_stb}), W'(0));
      rst_n = 1'b1;
      m = 0;
      tag = "R9 R8 waking"; chk_kind = 3;
      for (int k = 0; k < WK; k++) cyc();
      chk_kind = 0;
      for (int k = 0; k < 4; k++) cyc();
      // R1 R4 R5: parallel, offset binary passthrough
      phase(1'b1, 1'b0, 0, 0, 60, "R1 R4 R5 par bin");
      // R1 R3 R4 R5: parallel, two's complement with inversion
      phase(1'b1, 1'b1, 1, 0, 80, "R1 R3 R4 R5 par twos");
      // R2 R3 R4 R6 R7: interleaved, two's complement
      phase(1'b0, 1'b1, 1, 1, 120, "R2 R3 R4 R6 R7 il twos");
      // R2 R6 R7: interleaved, binary, no inversion
      phase(1'b0, 1'b0, 0, 1, 100, "R2 R6 R7 il bin");
      // R8: power down in parallel mode
      phase(1'b1, 1'b1, 1, 0, 20, "R1 R5 pre-pd");
      pwr_dn = 1'b1; chk_kind = 0; cyc();
      tag = "R8 powered down"; chk_kind = 3;
      for (int k = 0; k < 15; k++) cyc();
      pwr_dn = 1'b0; tag = "R8 wake interval";
      for (int k = 0; k < WK; k++) cyc();
      phase(1'b1, 1'b1, 1, 0, 40, "R1 R3 R5 after wake");
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule